// File: doc/BRIEF.md
# SIMT Lane Predication Mask Unit

This block tracks which lanes of a single lockstep thread group are allowed to keep their results while the group walks through structured if/else/endif code under one shared program counter. Divergence is handled entirely by masking: both sides of a conditional always run, and the unit decides, lane by lane, whether the result of the current instruction may be written back. A sequencer presents one command per cycle (hold, if, else, endif) together with the per-lane condition bits of an if. The unit answers with the active mask and a per-lane commit enable.

Nested conditionals are handled by a stack of saved parent masks. An if pushes the current mask and narrows it to the lanes whose condition is true. An else swaps to the parent's lanes that were not taken, so the condition does not have to be presented again. An endif pops the parent. A flag reports an all-zero mask, so that a sequencer can skip a path that no lane takes. Misuse of the stack sets a sticky error and is otherwise ignored.

Top module: `lane_mask_unit`

## Requirements
- R1: After reset the mask is all ones, the stack is empty, the error flag is 0 and the empty-mask flag is 0.
- R2: Command 2'b01 (if) pushes the current mask and sets the mask to the current mask ANDed with the condition bits (bit i is lane i); the new mask is visible in the cycle after the clock edge.
- R3: Command 2'b10 (else) sets the mask to the saved parent mask ANDed with the inverse of the current mask, leaving the stack depth unchanged.
- R4: Command 2'b11 (endif) pops the stack and restores the saved parent mask.
- R5: Command 2'b00 (hold) leaves the mask, the stack and the error flag unchanged, whatever the condition bits are.
- R6: The per-lane commit enable equals the active mask bit ANDed with the result-valid input, in the same cycle.
- R7: Conditionals nest up to DEPTH levels, and every endif restores the mask in force at its matching if.
- R8: An if with DEPTH masks already saved sets the error flag and changes neither mask nor stack.
- R9: An else or an endif with an empty stack sets the error flag and leaves the mask unchanged.
- R10: The empty-mask flag is 1 exactly when every mask bit is 0.
- R11: The error flag, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 00 hold, 01 if, 10 else, 11 endif |
| cond_i | input | LANES | Per-lane condition bits used by if |
| res_valid_i | input | 1 | The lanes produce a result this cycle |
| mask_o | output | LANES | Current active-lane mask |
| commit_o | output | LANES | Per-lane write-back enable |
| none_active_o | output | 1 | Current mask is all zeros |
| err_o | output | 1 | Sticky stack misuse flag |

## Verification
The bench sweeps every condition value at the top level and every pair of conditions across two nesting levels, so an else that reused the condition instead of the parent mask would re-enable lanes that the outer if had switched off, and an endif that restored all ones would lose the outer mask. It fills the stack to its full depth and pushes once more: a design off by one in its full test would either corrupt the deepest saved mask or refuse the last legal level. Else and endif on an empty stack are driven both right after reset and after unwinding a deep nest, which catches a counter that wraps instead of flagging. A long pseudo-random command stream, checked against an arithmetic model, then covers arbitrary mixes, including holds whose condition bits must have no effect.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
  typedef enum logic [1:0] {
    MC_HOLD  = 2'b00,
    MC_IF    = 2'b01,
    MC_ELSE  = 2'b10,
    MC_ENDIF = 2'b11
  } mask_cmd_e;
endpackage

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_i,
  input  logic                          pop_i,
  input  logic [W-1:0]                  din_i,
  output logic [W-1:0]                  top_o,
  output logic                          full_o,
  output logic                          empty_o,
  output logic [$clog2(DEPTH+1)-1:0]    level_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slots [DEPTH];
  logic [CW-1:0] level_q;
  logic [CW-1:0] below;

  assign below   = level_q - CW'(1);
  assign full_o  = (level_q == CW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign level_o = level_q;
  assign top_o   = empty_o ? '1 : slots[AW'(below)];

  always_ff @(posedge clk) begin
    if (push_i && !full_o) slots[AW'(level_q)] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    level_q <= '0;
    else if (push_i && !full_o)    level_q <= level_q + CW'(1);
    else if (pop_i && !empty_o)    level_q <= below;
  end
endmodule

// File: rtl/mask_next.sv
module mask_next
  import lane_mask_pkg::*;
#(
  parameter int W = 4
) (
  input  mask_cmd_e    cmd_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] parent_i,
  input  logic         full_i,
  input  logic         empty_i,
  output logic [W-1:0] nxt_o,
  output logic         push_ok_o,
  output logic         flip_ok_o,
  output logic         pop_ok_o,
  output logic         fault_o
);
  function automatic logic [W-1:0] f_narrow(logic [W-1:0] cur, logic [W-1:0] cond);
    return cur & cond;
  endfunction

  function automatic logic [W-1:0] f_flip(logic [W-1:0] parent, logic [W-1:0] cur);
    return parent & ~cur;
  endfunction

  always_comb begin
    push_ok_o = (cmd_i == MC_IF)    && !full_i;
    flip_ok_o = (cmd_i == MC_ELSE)  && !empty_i;
    pop_ok_o  = (cmd_i == MC_ENDIF) && !empty_i;
    fault_o   = ((cmd_i == MC_IF) && full_i) ||
                (((cmd_i == MC_ELSE) || (cmd_i == MC_ENDIF)) && empty_i);
    nxt_o = cur_i;
    if (push_ok_o)      nxt_o = f_narrow(cur_i, cond_i);
    else if (flip_ok_o) nxt_o = f_flip(parent_i, cur_i);
    else if (pop_ok_o)  nxt_o = parent_i;
  end
endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
  import lane_mask_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_i,
  input  logic [LANES-1:0] cond_i,
  input  logic             res_valid_i,
  output logic [LANES-1:0] mask_o,
  output logic [LANES-1:0] commit_o,
  output logic             none_active_o,
  output logic             err_o
);
  localparam int CW = $clog2(DEPTH + 1);

  mask_cmd_e        cmd;
  logic [LANES-1:0] mask_q, mask_d, parent;
  logic             full, empty, push_ok, flip_ok, pop_ok, fault_evt;
  logic [CW-1:0]    level;
  logic             err_q;

  assign cmd = mask_cmd_e'(cmd_i);

  mask_stack #(.W(LANES), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_ok), .pop_i(pop_ok),
    .din_i(mask_q), .top_o(parent), .full_o(full), .empty_o(empty),
    .level_o(level)
  );

  mask_next #(.W(LANES)) u_next (
    .cmd_i(cmd), .cur_i(mask_q), .cond_i(cond_i), .parent_i(parent),
    .full_i(full), .empty_i(empty), .nxt_o(mask_d), .push_ok_o(push_ok),
    .flip_ok_o(flip_ok), .pop_ok_o(pop_ok), .fault_o(fault_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      err_q  <= err_q | fault_evt;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign commit_o[g] = mask_q[g] & res_valid_i;
  end

  assign mask_o        = mask_q;
  assign none_active_o = ~|mask_q;
  assign err_o         = err_q;
endmodule

// File: rtl/lane_mask_chk.sv
module lane_mask_chk #(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [LANES-1:0]           mask_o,
  input logic [LANES-1:0]           commit_o,
  input logic                       err_o,
  input logic                       push_ok,
  input logic                       flip_ok,
  input logic                       pop_ok,
  input logic                       fault_evt,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  a_r2_if_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> ((mask_o & ~$past(mask_o)) == '0));
  a_r3_else_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ok |=> ((mask_o & $past(mask_o)) == '0));
  a_r4_endif_widens: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (($past(mask_o) & ~mask_o) == '0));
  a_r6_commit_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_o & ~mask_o) == '0));
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= ($clog2(DEPTH+1))'(DEPTH)));
  a_r8_fault_holds_mask: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> $stable(mask_o));
  a_r9_fault_raises_err: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> err_o);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind lane_mask_unit lane_mask_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_o(mask_o), .commit_o(commit_o),
  .err_o(err_o), .push_ok(push_ok), .flip_ok(flip_ok), .pop_ok(pop_ok),
  .fault_evt(fault_evt), .level(level)
);

// File: tb/sim_lane_mask_unit.sv
module sim_lane_mask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cmd = 2'b00;
  logic [L-1:0] cond = '0;
  logic         valid = 1'b0;
  logic [L-1:0] mask_o, commit_o;
  logic         none_o, err_o;

  lane_mask_unit #(.LANES(L), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .cond_i(cond),
    .res_valid_i(valid), .mask_o(mask_o), .commit_o(commit_o),
    .none_active_o(none_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  logic [L-1:0] m_mask;
  logic [L-1:0] m_stk [D];
  int           m_dep;
  bit           m_err;

  task automatic chk(string req, logic [L-1:0] act, logic [L-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic model_step(logic [1:0] c, logic [L-1:0] cd);
    logic [L-1:0] t;
    case (c)
      2'b01: if (m_dep == D) m_err = 1'b1;
             else begin
               m_stk[m_dep] = m_mask;
               m_dep++;
               for (int i = 0; i < L; i++) t[i] = m_mask[i] && cd[i];
               m_mask = t;
             end
      2'b10: if (m_dep == 0) m_err = 1'b1;
             else begin
               for (int i = 0; i < L; i++) t[i] = m_stk[m_dep-1][i] && !m_mask[i];
               m_mask = t;
             end
      2'b11: if (m_dep == 0) m_err = 1'b1;
             else begin
               m_dep--;
               m_mask = m_stk[m_dep];
             end
      default: ;
    endcase
  endtask

  task automatic check_all(string tag);
    logic v;
    chk(tag, mask_o, m_mask);
    chk("R10", {{(L-1){1'b0}}, none_o}, {{(L-1){1'b0}}, (m_mask == '0)});
    chk("R11", {{(L-1){1'b0}}, err_o}, {{(L-1){1'b0}}, m_err});
    v = rnd()[16];
    valid = v;
    #1;
    chk("R6", commit_o, m_mask & {L{v}});
  endtask

  task automatic issue(logic [1:0] c, logic [L-1:0] cd, string tag);
    cmd  = c;
    cond = cd;
    model_step(c, cd);
    @(negedge clk);
    cmd = 2'b00;
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd = 2'b00;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_mask = '1;
    m_dep = 0;
    m_err = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_all("R1");
    // R9: else/endif on empty stack
    issue(2'b10, 4'b0110, "R9");
    issue(2'b11, 4'b0000, "R9");
    issue(2'b00, 4'b1010, "R5");

    // R2/R3/R4/R5 top-level sweep of every condition
    do_reset();
    for (int c = 0; c < 16; c++) begin
      issue(2'b01, L'(c), "R2");
      issue(2'b00, ~L'(c), "R5");
      issue(2'b10, L'(c), "R3");
      issue(2'b11, 4'b0101, "R4");
    end

    // R7: two-level exhaustive nesting
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        issue(2'b01, L'(a), "R7");
        issue(2'b01, L'(b), "R7");
        issue(2'b10, 4'b0000, "R7");
        issue(2'b11, 4'b0000, "R7");
        issue(2'b10, 4'b0000, "R7");
        issue(2'b11, 4'b0000, "R7");
      end
    end

    // R8: fill to DEPTH then one more
    do_reset();
    for (int k = 0; k < D; k++) issue(2'b01, ~L'(1 << (k % L)) | L'(k), "R7");
    issue(2'b01, 4'b0000, "R8");
    for (int k = 0; k < D; k++) issue(2'b11, 4'b0000, "R7");
    issue(2'b11, 4'b0000, "R9");

    // R7: pseudo-random command stream
    do_reset();
    for (int s = 0; s < 2000; s++) begin
      logic [31:0] r;
      r = rnd();
      issue(r[21:20], r[27:24], "R7");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule